// File: doc/BRIEF.md
# Frequency Synthesizer Configuration and Clock Switchover Controller

This block is the digital control wrapper that sits around an on-chip frequency-synthesis loop. Software programs a multiplication factor and an output-divider choice into a staging register. It commits them through a two-key unlock sequence, turns the loop on, waits for the loop to report lock, and only then asks for the system clock to move over to the synthesized clock. The loop itself, its oscillator and its phase detector are not part of the block. They appear only as an enable output, the committed setting outputs and a lock input.

Before a setting is accepted, the block checks it in integer kHz arithmetic against three windows: the reference frequency, the resulting output frequency, and the internal oscillator frequency. The internal oscillator frequency is the output frequency times the output divide. A rejected setting raises a sticky error and leaves the loop unusable until a legal setting is committed. Out of reset, and whenever lock is lost while connected, the clock-select output stays on (or falls back to) the raw reference. Clock-select is a single registered bit that an external glitch-free multiplexer consumes. A programmable reference-cycle budget bounds the lock wait, and overrunning it raises a sticky timeout flag.

Register map, written through `wr_en`/`wr_addr`/`wr_data` (one write per cycle):
- address 0, staging: bits [4:0] hold M-1 for a multiplier M of 1 to 32; bits [6:5] hold the divider select P, and the divide is 2^(P+1), that is 2, 4, 8 or 16.
- address 1, control: bit 0 enables the loop, bit 1 requests connection, and bit 7 clears all sticky flags. The enable and connect bits are rewritten on every control write.
- address 2, unlock key register.

Top module: `pll_switch_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `clk_sel`, `pll_enable`, `cfg_err`, `lock_timeout` and `lock_lost` are 0, and `pll_mcode` and `pll_dsel` are 0.
- R2: A commit copies staging bits [4:0] to `pll_mcode` and bits [6:5] to `pll_dsel`. The copy is visible in the cycle after the edge that takes the second key.
- R3: A commit happens only when a write of 0xAA to address 2 is followed, as the very next write, by a write of 0x55 to address 2. Any other write in between, including a write to another address, abandons the sequence. A lone 0x55 write does nothing.
- R4: Let ref = `ref_khz`, Fout = ref*M and Fcco = Fout*2^(P+1). A committed setting is legal only when ref lies in 10000..25000, Fout lies in 10000..60000 and Fcco lies in 156000..320000, all inclusive. An illegal commit leaves `pll_mcode`/`pll_dsel` unchanged and sets `cfg_err`, and `cfg_err` stays set until it is cleared.
- R5: An enable request has no effect on `pll_enable` or `clk_sel` until a legal setting has been committed, or after an illegal commit.
- R6: With a legal setting committed, `pll_enable` rises in the second cycle after the edge that takes an enabling control write. It does not rise in the first cycle.
- R7: `clk_sel` goes to 1 only on a connect request made while the loop is enabled and locked. It becomes visible one cycle after that write is taken. A connect request made before lock is discarded.
- R8: If the loop stays enabled without lock for `lock_limit` consecutive cycles, `lock_timeout` becomes 1 after exactly that many cycles and stays set. A `lock_limit` of 0 disables the timeout.
- R9: If `pll_lock` falls while connected, `clk_sel` returns to 0 at the next edge and `lock_lost` is set. The connect request is dropped, so a later return of lock does not reconnect.
- R10: A control write with bit 0 clear brings `pll_enable` and `clk_sel` to 0 in the second cycle after the edge that takes the write.
- R11: A commit attempted while the loop is enabled is ignored. `pll_mcode`/`pll_dsel` do not change and `cfg_err` is not set.
- R12: A control write with bit 7 set clears `cfg_err`, `lock_timeout` and `lock_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register address (0 staging, 1 control, 2 key) |
| wr_data | input | 8 | Register write data |
| ref_khz | input | REF_W (16) | Reference frequency in kHz, used for the legality check |
| lock_limit | input | LIM_W (16) | Lock-wait budget in reference cycles; 0 disables the timeout |
| pll_lock | input | 1 | Lock report from the synthesis loop |
| pll_enable | output | 1 | Turns the synthesis loop on |
| pll_mcode | output | 5 | Committed multiplier code (M-1) |
| pll_dsel | output | 2 | Committed divider select (divide 2^(P+1)) |
| clk_sel | output | 1 | 0 selects the reference, 1 selects the synthesized clock |
| cfg_err | output | 1 | Sticky illegal-setting flag |
| lock_timeout | output | 1 | Sticky lock-wait overrun flag |
| lock_lost | output | 1 | Sticky loss-of-lock-while-connected flag |

## Verification
The assertions take for granted that `pll_lock` is only reported while `pll_enable` is high, and that `ref_khz` and `lock_limit` are held steady while the loop is enabled. The bench drives `pll_lock` from a small lock model that counts enabled cycles before reporting lock and can be forced to drop lock. It also changes `ref_khz` only while the loop is off. Writes are single-cycle strobes issued one at a time, so key sequences and control writes never overlap, which is what the unlock-sequence checks rely on. The bench sweeps every multiplier and divider select at reference values on and just outside both edges of the legal window.

// File: rtl/pll_sw_pkg.sv
package pll_sw_pkg;

    // field widths of the programming interface
    localparam int unsigned MCODE_W = 5;
    localparam int unsigned DSEL_W  = 2;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 2;

    // register addresses
    localparam logic [ADDR_W-1:0] ADDR_STAGE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_KEY   = 2'd2;

    // unlock keys, first then second
    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;

    // legal windows in kHz
    localparam int unsigned REF_MIN_KHZ  = 10000;
    localparam int unsigned REF_MAX_KHZ  = 25000;
    localparam int unsigned OUT_MIN_KHZ  = 10000;
    localparam int unsigned OUT_MAX_KHZ  = 60000;
    localparam int unsigned CCO_MIN_KHZ  = 156000;
    localparam int unsigned CCO_MAX_KHZ  = 320000;

    typedef struct packed {
        logic [DSEL_W-1:0]  dsel;   // divide = 2^(dsel+1)
        logic [MCODE_W-1:0] mcode;  // multiplier - 1
    } synth_cfg_t;

    typedef struct packed {
        logic clr;   // clear sticky flags
        logic con;   // connect request
        logic en;    // loop enable
    } ctrl_bits_t;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_WAIT   = 2'd1,
        ST_LOCKED = 2'd2,
        ST_CONN   = 2'd3
    } sw_state_e;

    typedef enum logic {
        UNLOCK_IDLE  = 1'b0,
        UNLOCK_ARMED = 1'b1
    } unlock_state_e;

    // window check of a candidate setting against the given reference
    function automatic logic cfg_is_legal(input logic [31:0] ref_khz,
                                          input synth_cfg_t  cfg);
        logic [31:0] f_out;
        logic [31:0] f_cco;
        logic        ok_ref;
        logic        ok_out;
        logic        ok_cco;
        f_out  = ref_khz * (32'(cfg.mcode) + 32'd1);
        f_cco  = f_out << (32'(cfg.dsel) + 32'd1);
        ok_ref = (ref_khz >= REF_MIN_KHZ) && (ref_khz <= REF_MAX_KHZ);
        ok_out = (f_out   >= OUT_MIN_KHZ) && (f_out   <= OUT_MAX_KHZ);
        ok_cco = (f_cco   >= CCO_MIN_KHZ) && (f_cco   <= CCO_MAX_KHZ);
        return ok_ref && ok_out && ok_cco;
    endfunction

endpackage

// File: rtl/pll_sw_unlock.sv
module pll_sw_unlock
    import pll_sw_pkg::*;
#(
    parameter int unsigned REF_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [REF_W-1:0]     ref_khz,
    input  logic                 allow_commit,
    input  logic                 clr_flags,
    output synth_cfg_t           cfg_o,
    output logic                 cfg_ok_o,
    output logic                 cfg_err_o
);

    synth_cfg_t    stage_q;
    synth_cfg_t    applied_q;
    unlock_state_e unl_q;
    logic          ok_q;
    logic          err_q;

    logic key_wr;
    logic commit;
    logic legal;

    assign key_wr = wr_en && (wr_addr == ADDR_KEY);
    assign commit = key_wr && (wr_data == KEY_SECOND) && (unl_q == UNLOCK_ARMED);
    assign legal  = cfg_is_legal(32'(ref_khz), stage_q);

    // staging register
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (wr_en && (wr_addr == ADDR_STAGE)) begin
            stage_q <= synth_cfg_t'(wr_data[MCODE_W+DSEL_W-1:0]);
        end
    end

    // two-key sequencer: any write resolves the armed state
    always_ff @(posedge clk) begin
        if (rst) begin
            unl_q <= UNLOCK_IDLE;
        end else if (wr_en) begin
            if (key_wr && (wr_data == KEY_FIRST)) begin
                unl_q <= UNLOCK_ARMED;
            end else begin
                unl_q <= UNLOCK_IDLE;
            end
        end
    end

    // committed setting, validity and sticky error
    always_ff @(posedge clk) begin
        if (rst) begin
            applied_q <= '0;
            ok_q      <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (clr_flags) begin
                err_q <= 1'b0;
            end
            if (commit && allow_commit) begin
                if (legal) begin
                    applied_q <= stage_q;
                    ok_q      <= 1'b1;
                end else begin
                    ok_q  <= 1'b0;
                    err_q <= 1'b1;
                end
            end
        end
    end

    assign cfg_o     = applied_q;
    assign cfg_ok_o  = ok_q;
    assign cfg_err_o = err_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_addr == ADDR_KEY) && (wr_data == KEY_SECOND)) |=> $stable(applied_q)); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr_flags) |=> err_q); // R4
    AST_NO_COMMIT_RUNNING: assert property (@(posedge clk) disable iff (rst)
        !allow_commit |=> $stable(applied_q) && ($rose(err_q) == 1'b0)); // R11

endmodule

// File: rtl/pll_sw_timer.sv
module pll_sw_timer #(
    parameter int unsigned LIM_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              waiting,
    input  logic [LIM_W-1:0]  lock_limit,
    input  logic              clr_flags,
    output logic              timeout_o
);

    localparam logic [LIM_W-1:0] CNT_MAX = '1;

    logic [LIM_W-1:0] cnt_q;
    logic             to_q;
    logic             hit;

    assign hit = waiting && (lock_limit != '0) && (cnt_q == LIM_W'(lock_limit - 1'b1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!waiting) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            to_q <= 1'b0;
        end else if (clr_flags) begin
            to_q <= 1'b0;
        end else if (hit) begin
            to_q <= 1'b1;
        end
    end

    assign timeout_o = to_q;

    AST_TIMEOUT_WAITING: assert property (@(posedge clk) disable iff (rst)
        $rose(to_q) |-> $past(waiting)); // R8
    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (to_q && !clr_flags) |=> to_q); // R8

endmodule

// File: rtl/pll_sw_fsm.sv
module pll_sw_fsm
    import pll_sw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  ctrl_bits_t ctrl_bits,
    input  logic       pll_lock,
    input  logic       cfg_ok,
    output sw_state_e  state_o,
    output logic       pll_en_o,
    output logic       clk_sel_o,
    output logic       lock_lost_o,
    output logic       clr_o
);

    sw_state_e state_q;
    sw_state_e state_d;
    logic      en_q;
    logic      con_q;
    logic      con_d;
    logic      pll_en_q;
    logic      sel_q;
    logic      lost_q;
    logic      locked_phase;

    assign clr_o        = ctrl_wr && ctrl_bits.clr;
    assign locked_phase = (state_q == ST_LOCKED) || (state_q == ST_CONN);
    assign con_d        = ctrl_wr ? (ctrl_bits.en && ctrl_bits.con) : con_q;

    // control register; connect survives only while locked
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            con_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                en_q <= ctrl_bits.en;
            end
            con_q <= con_d && locked_phase && pll_lock;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BYPASS: if (en_q && cfg_ok) state_d = ST_WAIT;
            ST_WAIT: begin
                if (!en_q)         state_d = ST_BYPASS;
                else if (pll_lock) state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (!en_q)          state_d = ST_BYPASS;
                else if (!pll_lock) state_d = ST_WAIT;
                else if (con_q)     state_d = ST_CONN;
            end
            ST_CONN: begin
                if (!en_q)          state_d = ST_BYPASS;
                else if (!pll_lock) state_d = ST_WAIT;
                else if (!con_q)    state_d = ST_LOCKED;
            end
            default: state_d = ST_BYPASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_BYPASS;
            pll_en_q <= 1'b0;
            sel_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            pll_en_q <= (state_d != ST_BYPASS);
            sel_q    <= (state_d == ST_CONN);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lost_q <= 1'b0;
        end else if (clr_o) begin
            lost_q <= 1'b0;
        end else if ((state_q == ST_CONN) && !pll_lock) begin
            lost_q <= 1'b1;
        end
    end

    assign state_o     = state_q;
    assign pll_en_o    = pll_en_q;
    assign clk_sel_o   = sel_q;
    assign lock_lost_o = lost_q;

    AST_SEL_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_q) |-> $past(pll_lock)); // R7
    AST_SEL_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        sel_q |-> pll_en_q); // R7
    AST_LOSS_DROPS_SEL: assert property (@(posedge clk) disable iff (rst)
        (sel_q && !pll_lock) |=> !sel_q); // R9
    AST_LOST_ONLY_CONN: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_q) |-> $past(sel_q)); // R9
    AST_EN_NEEDS_CFG: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_en_q) |-> $past(cfg_ok)); // R5

endmodule

// File: rtl/pll_switch_ctrl.sv
module pll_switch_ctrl
    import pll_sw_pkg::*;
#(
    parameter int unsigned REF_W = 16,
    parameter int unsigned LIM_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [REF_W-1:0]    ref_khz,
    input  logic [LIM_W-1:0]    lock_limit,
    input  logic                pll_lock,
    output logic                pll_enable,
    output logic [MCODE_W-1:0]  pll_mcode,
    output logic [DSEL_W-1:0]   pll_dsel,
    output logic                clk_sel,
    output logic                cfg_err,
    output logic                lock_timeout,
    output logic                lock_lost
);

    sw_state_e  state;
    synth_cfg_t cfg;
    logic       cfg_ok;
    logic       clr_flags;
    logic       ctrl_wr;
    ctrl_bits_t ctrl_bits;

    assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
    assign ctrl_bits = '{clr: wr_data[7], con: wr_data[1], en: wr_data[0]};

    pll_sw_unlock #(.REF_W(REF_W)) u_unlock (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ref_khz      (ref_khz),
        .allow_commit (state == ST_BYPASS),
        .clr_flags    (clr_flags),
        .cfg_o        (cfg),
        .cfg_ok_o     (cfg_ok),
        .cfg_err_o    (cfg_err)
    );

    pll_sw_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (ctrl_wr),
        .ctrl_bits   (ctrl_bits),
        .pll_lock    (pll_lock),
        .cfg_ok      (cfg_ok),
        .state_o     (state),
        .pll_en_o    (pll_enable),
        .clk_sel_o   (clk_sel),
        .lock_lost_o (lock_lost),
        .clr_o       (clr_flags)
    );

    pll_sw_timer #(.LIM_W(LIM_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .waiting    (state == ST_WAIT),
        .lock_limit (lock_limit),
        .clr_flags  (clr_flags),
        .timeout_o  (lock_timeout)
    );

    assign pll_mcode = cfg.mcode;
    assign pll_dsel  = cfg.dsel;

endmodule

// File: tb/tb_pll_switch_ctrl.sv
`timescale 1ns/1ps
module tb_pll_switch_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] ref_khz = 16'd12000;
    logic [15:0] lock_limit = 16'd1000;
    logic        pll_lock;
    logic        pll_enable;
    logic [4:0]  pll_mcode;
    logic [1:0]  pll_dsel;
    logic        clk_sel;
    logic        cfg_err;
    logic        lock_timeout;
    logic        lock_lost;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // lock model: reports lock after lock_delay enabled cycles, unless killed
    int lock_delay = 1000;
    bit kill_lock = 1'b0;
    int en_cnt = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) en_cnt <= pll_enable ? en_cnt + 1 : 0;
    assign pll_lock = pll_enable && (en_cnt >= lock_delay) && !kill_lock;

    pll_switch_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ref_khz(ref_khz), .lock_limit(lock_limit), .pll_lock(pll_lock),
        .pll_enable(pll_enable), .pll_mcode(pll_mcode), .pll_dsel(pll_dsel),
        .clk_sel(clk_sel), .cfg_err(cfg_err), .lock_timeout(lock_timeout),
        .lock_lost(lock_lost)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one write; returns on the falling edge right after the capturing edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic bit legal_exp(input int rf, input int m, input int p);
        int fo;
        int fc;
        fo = rf * m;
        fc = fo * (2 << p);
        return (rf >= 10000 && rf <= 25000) && (fo >= 10000 && fo <= 60000) &&
               (fc >= 156000 && fc <= 320000);
    endfunction

    initial begin
        int exp_m;
        int exp_p;
        int refs [5];
        refs = '{12000, 10000, 25000, 9999, 25001};
        exp_m = 0; exp_p = 0;

        // R1: reset state
        cycles(3);
        chk("R1 clk_sel in reset", clk_sel, 0);
        chk("R1 pll_enable in reset", pll_enable, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 pll_enable", pll_enable, 0);
        chk("R1 flags", {cfg_err, lock_timeout, lock_lost}, 0);
        chk("R1 mcode", pll_mcode, 0);
        chk("R1 dsel", pll_dsel, 0);

        // R5: enable with nothing committed
        wr(2'd1, 8'h01);
        cycles(3);
        chk("R5 enable blocked, no setting", pll_enable, 0);
        chk("R5 clk_sel stays bypass", clk_sel, 0);
        wr(2'd1, 8'h80);

        // R3: aborted and stray key sequences (stage M=5, P=1)
        wr(2'd0, {1'b0, 2'd1, 5'd4});
        wr(2'd2, 8'hAA); wr(2'd1, 8'h00); wr(2'd2, 8'h55);
        chk("R3 abort by control write", pll_mcode, 0);
        wr(2'd2, 8'hAA); wr(2'd0, {1'b0, 2'd1, 5'd4}); wr(2'd2, 8'h55);
        chk("R3 abort by staging write", pll_mcode, 0);
        wr(2'd2, 8'hAA); wr(2'd2, 8'h12); wr(2'd2, 8'h55);
        chk("R3 abort by wrong key", pll_mcode, 0);
        wr(2'd2, 8'h55);
        chk("R3 lone second key", pll_mcode, 0);
        chk("R3 no error from aborted sequences", cfg_err, 0);
        wr(2'd2, 8'hAA); wr(2'd2, 8'h55);
        chk("R2 mcode after commit", pll_mcode, 4);
        chk("R2 dsel after commit", pll_dsel, 1);
        exp_m = 4; exp_p = 1;

        // R4/R5/R6/R10: sweep of every setting at several references
        for (int ri = 0; ri < 5; ri++) begin
            ref_khz = 16'(refs[ri]);
            for (int m = 1; m <= 32; m++) begin
                for (int p = 0; p < 4; p++) begin
                    bit lg;
                    lg = legal_exp(refs[ri], m, p);
                    wr(2'd1, 8'h80);
                    wr(2'd0, {1'b0, 2'(p), 5'(m - 1)});
                    wr(2'd2, 8'hAA);
                    wr(2'd2, 8'h55);
                    if (lg) begin exp_m = m - 1; exp_p = p; end
                    chk($sformatf("R4 cfg_err ref=%0d m=%0d p=%0d", refs[ri], m, p), cfg_err, lg ? 0 : 1);
                    chk($sformatf("R2 mcode ref=%0d m=%0d p=%0d", refs[ri], m, p), pll_mcode, exp_m);
                    chk($sformatf("R2 dsel ref=%0d m=%0d p=%0d", refs[ri], m, p), pll_dsel, exp_p);
                    wr(2'd1, 8'h01);
                    chk("R6 no enable in first cycle", pll_enable, 0);
                    @(negedge clk);
                    chk($sformatf("R5 enable gate ref=%0d m=%0d p=%0d", refs[ri], m, p), pll_enable, lg ? 1 : 0);
                    wr(2'd1, 8'h00);
                    @(negedge clk);
                    chk("R10 disable", pll_enable, 0);
                end
            end
        end

        // legal setting for the sequencing tests
        ref_khz = 16'd12000;
        lock_delay = 4;
        wr(2'd1, 8'h80);
        wr(2'd0, {1'b0, 2'd1, 5'd4});
        wr(2'd2, 8'hAA); wr(2'd2, 8'h55);
        chk("R2 mcode reload", pll_mcode, 4);

        // R7: connect before lock is dropped
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h03);
        cycles(12);
        chk("R7 early connect discarded", clk_sel, 0);
        chk("R7 loop enabled", pll_enable, 1);
        wr(2'd1, 8'h03);
        chk("R7 not yet connected", clk_sel, 0);
        @(negedge clk);
        chk("R7 connected", clk_sel, 1);

        // R11: commit while running is ignored
        wr(2'd0, {1'b0, 2'd2, 5'd2});
        wr(2'd2, 8'hAA); wr(2'd2, 8'h55);
        cycles(2);
        chk("R11 mcode unchanged", pll_mcode, 4);
        chk("R11 dsel unchanged", pll_dsel, 1);
        chk("R11 no error", cfg_err, 0);
        chk("R11 still connected", clk_sel, 1);

        // R9: loss of lock while connected
        kill_lock = 1'b1;
        @(negedge clk);
        chk("R9 bypass after loss", clk_sel, 0);
        chk("R9 lock_lost set", lock_lost, 1);
        kill_lock = 1'b0;
        cycles(10);
        chk("R9 no reconnect", clk_sel, 0);
        chk("R9 lock_lost sticky", lock_lost, 1);

        // R12: clear flags keeping enable
        wr(2'd1, 8'h81);
        chk("R12 lock_lost cleared", lock_lost, 0);

        // R10: disable
        wr(2'd1, 8'h00);
        @(negedge clk);
        chk("R10 pll_enable off", pll_enable, 0);
        chk("R10 clk_sel off", clk_sel, 0);

        // R8: lock timeout after exactly lock_limit waiting cycles
        lock_delay = 1000000;
        lock_limit = 16'd20;
        wr(2'd1, 8'h01);
        cycles(20);
        chk("R8 no timeout before limit", lock_timeout, 0);
        @(negedge clk);
        chk("R8 timeout at limit", lock_timeout, 1);
        cycles(5);
        chk("R8 timeout sticky", lock_timeout, 1);
        wr(2'd1, 8'h80);
        chk("R12 timeout cleared", lock_timeout, 0);

        // R12: clear illegal-setting error
        wr(2'd0, {1'b0, 2'd3, 5'd31});
        wr(2'd2, 8'hAA); wr(2'd2, 8'h55);
        chk("R4 illegal sets error", cfg_err, 1);
        wr(2'd1, 8'h80);
        chk("R12 cfg_err cleared", cfg_err, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule